// File: doc/BRIEF.md
# Subblocked Write-Through Data Cache with Allocate-on-Store

This block is a direct-mapped data cache for a processor load/store port. Each line holds several one-word subblocks, and each subblock carries its own valid bit beside a single tag per line. Because the cache is write-through, every store goes out on a write-through port in the cycle it is accepted. The store also lands in the data array and the tag array that same cycle, with no fill and no stall, whether the line already holds the store's tag or not.

On a store whose tag differs from the stored tag, the tag is replaced and only the written subblock stays valid. Memory still holds correct copies of the old line, so nothing is lost. A load hits only when the tag matches and the addressed subblock is valid. On a miss the controller fetches that one word from a simple memory read port, answers the load with it, and installs it under the same tag-replacement rule that stores use.

With the default parameters the word address is 16 bits. Bits [1:0] select the word in a line, bits [7:2] select one of 64 lines, and bits [15:8] form the tag.

Top module: `sbwt_cache`

## Requirements
- R1: After reset every subblock is invalid, so the first load of any address misses. While idle after reset, req_ready is 1 and mem_rd_req, wt_valid and resp_valid are 0.
- R2: A store accepted in a cycle (req_valid=1, req_write=1, req_ready=1) drives wt_valid=1 in that same cycle, with wt_addr equal to req_addr and wt_data equal to req_wdata.
- R3: A load whose tag matches and whose addressed subblock is valid returns resp_valid=1 and the stored word in the cycle it is presented, and it makes no memory request.
- R4: Stores never stall. req_ready stays 1 in the cycle after an accepted store, whether the store hit or missed.
- R5: A store whose tag differs from the line's tag replaces the tag and clears the valid bits of every other subblock in that line. A later load of any other word under the old or the new tag misses.
- R6: A store whose tag matches into an invalid subblock makes that subblock valid and leaves the line's other valid subblocks readable as hits.
- R7: A store that hits overwrites the word. A load of the same address in the very next cycle returns the new data.
- R8: On a load miss, req_ready falls and mem_rd_req rises in the next cycle with mem_rd_addr equal to the load address. Both hold until mem_rd_valid is 1. In that cycle resp_valid=1 and resp_rdata equals mem_rd_data, and the controller is idle again one cycle later.
- R9: A fetched word becomes valid under the load's tag. If the tag matched, the other valid subblocks are kept; if it differed, they are cleared.
- R10: Loads never assert wt_valid, and stores never assert mem_rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| resp_valid | output | 1 | Load data valid |
| resp_rdata | output | 32 | Load data |
| mem_rd_req | output | 1 | One-word fetch request to memory |
| mem_rd_addr | output | 16 | Word address of the fetch |
| mem_rd_valid | input | 1 | Fetched word present |
| mem_rd_data | input | 32 | Fetched word |
| wt_valid | output | 1 | Write-through store issued |
| wt_addr | output | 16 | Write-through word address |
| wt_data | output | 32 | Write-through data |

## Verification
The assertions assume the processor keeps req_valid low during reset. They also assume that memory raises mem_rd_valid only while mem_rd_req is high, and that a request presented while req_ready is low counts as not accepted. The bench follows all three rules. It deasserts the request once a miss has been seen, and it pulses mem_rd_valid for one cycle after a chosen number of wait cycles, only while a fetch is pending. Fetch data is a fixed function of the address, so the expected load value never depends on what the cache holds.

// File: rtl/sbwt_pkg.sv
package sbwt_pkg;

    // Controller phase: accepting requests, or waiting on a one-word fetch.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } sbwt_state_e;

endpackage

// File: rtl/sbwt_tag_store.sv
module sbwt_tag_store #(
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 8,
    parameter int IDX_W      = 6,
    parameter int WSEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic              rd_hit,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [WSEL_W-1:0] wr_wsel
);

    logic [TAG_W-1:0]      tag_q [LINES];
    logic [LINE_WORDS-1:0] vld_q [LINES];

    logic [LINE_WORDS-1:0] wr_sel_oh;
    logic [LINE_WORDS-1:0] vld_d;
    logic [TAG_W-1:0]      tag_d;

    // One-hot subblock select for the written word.
    for (genvar gw = 0; gw < LINE_WORDS; gw++) begin : g_sel
        assign wr_sel_oh[gw] = (wr_wsel == WSEL_W'(gw));
    end

    // Same tag: add the subblock. New tag: only the written subblock survives.
    always_comb begin
        tag_d = wr_tag;
        if (tag_q[wr_idx] == wr_tag) begin
            vld_d = vld_q[wr_idx] | wr_sel_oh;
        end else begin
            vld_d = wr_sel_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                vld_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= tag_d;
        end
    end

    assign rd_hit = (tag_q[rd_idx] == rd_tag) && vld_q[rd_idx][rd_wsel];

endmodule

// File: rtl/sbwt_data_store.sv
module sbwt_data_store #(
    parameter int WORDS  = 256,
    parameter int WORD_W = 32,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data
);

    logic [WORD_W-1:0] word_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/sbwt_cache.sv
module sbwt_cache
    import sbwt_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [WORD_W-1:0] wt_data
);

    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W;
    localparam int SLOT_W = IDX_W + WSEL_W;
    localparam int WORDS  = LINES * LINE_WORDS;

    typedef struct packed {
        sbwt_state_e       state;
        logic [ADDR_W-1:0] pend_addr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic              lk_hit;
    logic [WORD_W-1:0] lk_data;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_addr;
    logic [WORD_W-1:0] upd_data;
    logic              store_go, load_go, fill_go;

    always_comb begin
        ctrl_d   = ctrl_q;
        req_ready = (ctrl_q.state == ST_IDLE);
        store_go = req_valid && req_write && req_ready;
        load_go  = req_valid && !req_write && req_ready;
        fill_go  = (ctrl_q.state == ST_FILL) && mem_rd_valid;

        // Stores and returning fetches share the single update port.
        upd_en   = store_go || fill_go;
        upd_addr = fill_go ? ctrl_q.pend_addr : req_addr;
        upd_data = fill_go ? mem_rd_data : req_wdata;

        resp_valid = fill_go || (load_go && lk_hit);
        resp_rdata = fill_go ? mem_rd_data : lk_data;

        mem_rd_req  = (ctrl_q.state == ST_FILL);
        mem_rd_addr = ctrl_q.pend_addr;

        wt_valid = store_go;
        wt_addr  = req_addr;
        wt_data  = req_wdata;

        if (load_go && !lk_hit) begin
            ctrl_d.state     = ST_FILL;
            ctrl_d.pend_addr = req_addr;
        end
        if (fill_go) begin
            ctrl_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, pend_addr: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    sbwt_tag_store #(
        .LINES      (LINES),
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W),
        .IDX_W      (IDX_W),
        .WSEL_W     (WSEL_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_addr[SLOT_W-1:WSEL_W]),
        .rd_tag  (req_addr[ADDR_W-1:SLOT_W]),
        .rd_wsel (req_addr[WSEL_W-1:0]),
        .rd_hit  (lk_hit),
        .wr_en   (upd_en),
        .wr_idx  (upd_addr[SLOT_W-1:WSEL_W]),
        .wr_tag  (upd_addr[ADDR_W-1:SLOT_W]),
        .wr_wsel (upd_addr[WSEL_W-1:0])
    );

    sbwt_data_store #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .AW     (SLOT_W)
    ) u_data (
        .clk     (clk),
        .rd_addr (req_addr[SLOT_W-1:0]),
        .rd_data (lk_data),
        .wr_en   (upd_en),
        .wr_addr (upd_addr[SLOT_W-1:0]),
        .wr_data (upd_data)
    );

endmodule

// File: rtl/sbwt_cache_chk.sv
module sbwt_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [WORD_W-1:0] req_wdata,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [WORD_W-1:0] resp_rdata,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic [WORD_W-1:0] mem_rd_data,
    input logic              wt_valid,
    input logic [ADDR_W-1:0] wt_addr,
    input logic [WORD_W-1:0] wt_data
);

    // R2
    wt_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ready) |->
            (wt_valid && wt_addr == req_addr && wt_data == req_wdata));

    // R4
    store_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ready) |=> req_ready);

    // R7
    store_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_write && req_ready) && req_valid && !req_write
         && req_ready && req_addr == $past(req_addr)) |->
            (resp_valid && resp_rdata == $past(req_wdata)));

    // R8
    miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready && !resp_valid) |=>
            (mem_rd_req && !req_ready && mem_rd_addr == $past(req_addr)));

    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R8
    fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid) |->
            (resp_valid && resp_rdata == mem_rd_data) ##1 req_ready);

    // R10
    wt_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wt_valid |-> (req_valid && req_write));

    // R10
    no_wt_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !wt_valid);

endmodule

bind sbwt_cache sbwt_cache_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_rdata   (resp_rdata),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .wt_valid     (wt_valid),
    .wt_addr      (wt_addr),
    .wt_data      (wt_data)
);

// File: tb/sbwt_cache_bench.sv
module sbwt_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        wt_valid;
    logic [15:0] wt_addr;
    logic [31:0] wt_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sbwt_cache u_sbwt_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data)
    );

    // Kinds: 0 = store, 1 = load expected to hit, 2 = load expected to miss.
    localparam int NVEC = 22;
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd2, 16'h1204, 32'h0},         // R1 cold miss
        {2'd1, 16'h1204, 32'h0},         // R9 fetched word hits
        {2'd2, 16'h1205, 32'h0},         // same tag, other word
        {2'd1, 16'h1204, 32'h0},         // R9 kept after same-tag fetch
        {2'd0, 16'h1206, 32'h1111_1111}, // R6 invalid word, tag match
        {2'd1, 16'h1206, 32'h1111_1111},
        {2'd1, 16'h1205, 32'h0},         // R6 others stay valid
        {2'd0, 16'h1206, 32'h2222_2222}, // R7 overwrite
        {2'd1, 16'h1206, 32'h2222_2222},
        {2'd0, 16'h3407, 32'h3333_3333}, // R5 tag replaced by store
        {2'd1, 16'h3407, 32'h3333_3333},
        {2'd2, 16'h1206, 32'h0},         // R5 old tag gone
        {2'd2, 16'h3407, 32'h0},         // R9 fetch replaced tag again
        {2'd2, 16'h3406, 32'h0},
        {2'd1, 16'h3407, 32'h0},
        {2'd0, 16'hFFFF, 32'hAAAA_AAAA}, // last line, last word
        {2'd1, 16'hFFFF, 32'hAAAA_AAAA},
        {2'd2, 16'hFFFC, 32'h0},
        {2'd1, 16'hFFFF, 32'hAAAA_AAAA},
        {2'd0, 16'h00FC, 32'h5555_5555}, // R5 tag 00 evicts tag FF
        {2'd2, 16'hFFFF, 32'h0},
        {2'd2, 16'h0000, 32'h0}
    };

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at the sample point of a cycle holding a load that missed.
    task automatic serve_miss(input logic [15:0] a, input int lat);
        @(negedge clk);
        req_valid = 1'b0;
        #5;
        check(mem_rd_req && !req_ready && mem_rd_addr == a, "R8 fetch issue",
              {31'd0, mem_rd_req, 16'd0, mem_rd_addr}, {31'd0, 1'b1, 16'd0, a});
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            #5;
            check(mem_rd_req && !req_ready && mem_rd_addr == a, "R8 hold",
                  {31'd0, mem_rd_req, 16'd0, mem_rd_addr}, {31'd0, 1'b1, 16'd0, a});
        end
        @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem_word(a);
        #5;
        check(resp_valid && resp_rdata == mem_word(a), "R8 return",
              {31'd0, resp_valid, resp_rdata}, {31'd0, 1'b1, mem_word(a)});
        @(negedge clk);
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        #5;
        check(req_ready && !mem_rd_req, "R8 idle again",
              {62'd0, req_ready, mem_rd_req}, 64'd2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(req_ready && !mem_rd_req && !wt_valid && !resp_valid, "R1 reset outputs",
              {60'd0, req_ready, mem_rd_req, wt_valid, resp_valid}, 64'h8);
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  kind;
            logic [15:0] a;
            logic [31:0] d;
            kind = VEC[i][49:48];
            a    = VEC[i][47:32];
            d    = VEC[i][31:0];
            @(negedge clk);
            req_valid = 1'b1;
            req_write = (kind == 2'd0);
            req_addr  = a;
            req_wdata = (kind == 2'd0) ? d : 32'h0;
            #5;
            if (kind == 2'd0) begin
                check(wt_valid && wt_addr == a && wt_data == d, "R2 write-through",
                      {15'd0, wt_valid, wt_addr, wt_data}, {15'd0, 1'b1, a, d});
                check(req_ready && !mem_rd_req && !resp_valid, "R4/R10 store",
                      {61'd0, req_ready, mem_rd_req, resp_valid}, 64'h4);
            end else if (kind == 2'd1) begin
                logic [31:0] e;
                e = (d == 32'h0) ? mem_word(a) : d;
                check(resp_valid && resp_rdata == e, "R3/R6/R7/R9 hit",
                      {31'd0, resp_valid, resp_rdata}, {31'd0, 1'b1, e});
                check(!wt_valid, "R10 load no write-through",
                      {63'd0, wt_valid}, 64'd0);
            end else begin
                check(!resp_valid && !wt_valid, "R1/R5/R9 miss",
                      {62'd0, resp_valid, wt_valid}, 64'd0);
                serve_miss(a, i % 3);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;

        // R4: back-to-back stores to two tags of one line, no stall between.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h7710; req_wdata = 32'hDEAD_0001;
        @(negedge clk);
        req_addr = 16'h8811; req_wdata = 32'hDEAD_0002;
        #5;
        check(req_ready && wt_valid && wt_data == 32'hDEAD_0002, "R4 back-to-back store",
              {31'd0, req_ready, wt_data}, {31'd0, 1'b1, 32'hDEAD_0002});
        @(negedge clk);
        req_write = 1'b0; req_addr = 16'h7710;
        #5;
        check(!resp_valid, "R5 evicted word misses",
              {63'd0, resp_valid}, 64'd0);
        serve_miss(16'h7710, 1);

        // R1: reset mid-run drops previously valid words.
        do_reset();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3407;
        #5;
        check(!resp_valid, "R1 valid cleared by reset",
              {63'd0, resp_valid}, 64'd0);
        serve_miss(16'h3407, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule